// File: doc/BRIEF.md
# Effective Address Offset Generator

This block forms the offset part of a memory operand address from up to four parts: an optional base register value, an optional index register value multiplied by a power-of-two scale, and an optional signed displacement. The displacement can be absent or 8, 16 or 32 bits wide, and is sign-extended to 32 bits. All arithmetic is two's complement and wraps modulo 2^32.

Along with the offset, the block picks the default segment. A base of register 4 (the stack pointer) or register 5 (the frame pointer) selects the stack segment. Every other case selects the data segment. The block also flags operand forms that are not allowed. The result is registered once, so a request accepted on one clock edge is visible on the outputs after that edge.

Top module: `ea_offset_gen`

## Requirements
- R1: offset_o = base + (index << scale) + sign-extended displacement, modulo 2^32, where an absent base, index or displacement counts as zero.
- R2: The scale code maps 0,1,2,3 to multipliers 1,2,4,8.
- R3: The displacement size code is 0 = none, 1 = 8 bits (disp_i[7:0]), 2 = 16 bits (disp_i[15:0]) and 3 = 32 bits. Each field is sign-extended, and disp_i bits above the selected width have no effect.
- R4: When idx_vld_i=1 and idx_sel_i=4 (the stack pointer), illegal_o=1.
- R5: When scale_i is not 0 and idx_vld_i=0, illegal_o=1. When idx_vld_i=0, the scale has no effect on the offset.
- R6: stack_seg_o=1 exactly when base_vld_i=1 and base_sel_i is 4 or 5. Otherwise it is 0, including when no base is present.
- R7: out_vld_o equals in_vld_i delayed by one cycle. The other outputs update only on a cycle where in_vld_i=1 and hold their values otherwise.
- R8: After reset, out_vld_o=0, offset_o=0, stack_seg_o=0 and illegal_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_vld_i | input | 1 | Request valid |
| base_vld_i | input | 1 | Base present |
| base_sel_i | input | 3 | Base register number |
| base_val_i | input | 32 | Base value |
| idx_vld_i | input | 1 | Index present |
| idx_sel_i | input | 3 | Index register number |
| idx_val_i | input | 32 | Index value |
| scale_i | input | 2 | Scale code |
| disp_sz_i | input | 2 | Displacement size code |
| disp_i | input | 32 | Displacement field |
| out_vld_o | output | 1 | Result valid |
| offset_o | output | 32 | Computed offset |
| stack_seg_o | output | 1 | 1 = stack segment, 0 = data segment |
| illegal_o | output | 1 | Illegal combination |

## Verification
Every result is due exactly one clock edge after the request is applied. The bench drives inputs on the falling edge and samples all outputs on the following falling edge, half a cycle after the capturing rising edge. Hold behaviour is checked by applying changed inputs with in_vld_i low and confirming on the next falling edge that the outputs still show the previous result.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned AW = 32;
  localparam int unsigned RW = 3;
  localparam logic [RW-1:0] REG_SP = 3'd4;
  localparam logic [RW-1:0] REG_BP = 3'd5;
  typedef enum logic [1:0] {DSZ_NONE = 2'd0, DSZ_8 = 2'd1, DSZ_16 = 2'd2, DSZ_32 = 2'd3} dsz_e;
  typedef struct packed {
    logic [AW-1:0] offset;
    logic          stack_seg;
    logic          illegal;
  } ea_res_t;
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
  parameter int unsigned W = 32
) (
  input  logic [1:0]   sz_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] ext_o
);
  always_comb begin
    unique case (sz_i)
      2'd1:    ext_o = {{(W-8){raw_i[7]}}, raw_i[7:0]};
      2'd2:    ext_o = {{(W-16){raw_i[15]}}, raw_i[15:0]};
      2'd3:    ext_o = raw_i;
      default: ext_o = '0;
    endcase
  end
endmodule

// File: rtl/ea_scale.sv
module ea_scale #(
  parameter int unsigned W = 32
) (
  input  logic         en_i,
  input  logic [1:0]   scale_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] shifted;
  always_comb begin
    shifted = val_i << scale_i;
    out_o   = en_i ? shifted : '0;
  end
endmodule

// File: rtl/ea_offset_gen.sv
module ea_offset_gen
  import ea_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_vld_i,
  input  logic          base_vld_i,
  input  logic [2:0]    base_sel_i,
  input  logic [31:0]   base_val_i,
  input  logic          idx_vld_i,
  input  logic [2:0]    idx_sel_i,
  input  logic [31:0]   idx_val_i,
  input  logic [1:0]    scale_i,
  input  logic [1:0]    disp_sz_i,
  input  logic [31:0]   disp_i,
  output logic          out_vld_o,
  output logic [31:0]   offset_o,
  output logic          stack_seg_o,
  output logic          illegal_o
);
  logic [AW-1:0] disp_ext, idx_term, base_term;
  ea_res_t res_d, res_q;
  logic vld_q;

  ea_disp_ext #(.W(AW)) u_disp (.sz_i(disp_sz_i), .raw_i(disp_i), .ext_o(disp_ext));
  ea_scale    #(.W(AW)) u_scl  (.en_i(idx_vld_i), .scale_i(scale_i),
                                .val_i(idx_val_i), .out_o(idx_term));

  always_comb begin
    base_term       = base_vld_i ? base_val_i : '0;
    res_d.offset    = base_term + idx_term + disp_ext;
    res_d.stack_seg = base_vld_i && (base_sel_i == REG_SP || base_sel_i == REG_BP);
    res_d.illegal   = (idx_vld_i && idx_sel_i == REG_SP) || (!idx_vld_i && scale_i != 2'd0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_vld_i;
      if (in_vld_i) res_q <= res_d;
    end
  end

  assign out_vld_o   = vld_q;
  assign offset_o    = res_q.offset;
  assign stack_seg_o = res_q.stack_seg;
  assign illegal_o   = res_q.illegal;
endmodule

// File: rtl/ea_offset_gen_chk.sv
module ea_offset_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_vld_i,
  input logic        base_vld_i,
  input logic [2:0]  base_sel_i,
  input logic        idx_vld_i,
  input logic [2:0]  idx_sel_i,
  input logic [1:0]  scale_i,
  input logic        out_vld_o,
  input logic [31:0] offset_o,
  input logic        stack_seg_o,
  input logic        illegal_o
);
  p_vld_delay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_vld_i |=> out_vld_o);
  p_vld_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_vld_i |=> !out_vld_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_vld_i |=> ($stable(offset_o) && $stable(stack_seg_o) && $stable(illegal_o)));
  p_sp_index_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_vld_i && idx_vld_i && idx_sel_i == 3'd4) |=> illegal_o);
  p_scale_noidx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_vld_i && !idx_vld_i && scale_i != 2'd0) |=> illegal_o);
  p_no_base_seg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_vld_i && !base_vld_i) |=> !stack_seg_o);
  p_stack_base_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_vld_i && base_vld_i && (base_sel_i == 3'd4 || base_sel_i == 3'd5)) |=> stack_seg_o);
endmodule

bind ea_offset_gen ea_offset_gen_chk u_chk (.*);

// File: tb/tb_ea_offset_gen.sv
module tb_ea_offset_gen;
  logic clk_i = 0, rst_ni = 0;
  logic in_vld_i = 0, base_vld_i = 0, idx_vld_i = 0;
  logic [2:0] base_sel_i = 0, idx_sel_i = 0;
  logic [31:0] base_val_i = 0, idx_val_i = 0, disp_i = 0;
  logic [1:0] scale_i = 0, disp_sz_i = 0;
  logic out_vld_o, stack_seg_o, illegal_o;
  logic [31:0] offset_o;
  int checks = 0, errors = 0;
  logic [31:0] e_off; logic e_seg, e_ill;

  always #2 clk_i = ~clk_i;

  ea_offset_gen dut (.*);

  function automatic logic [31:0] f_off(logic bv, logic [31:0] b, logic iv, logic [31:0] x,
                                        logic [1:0] s, logic [1:0] dz, logic [31:0] d);
    logic [31:0] de;
    case (dz)
      2'd1: de = 32'($signed(d[7:0]));
      2'd2: de = 32'($signed(d[15:0]));
      2'd3: de = d;
      default: de = 0;
    endcase
    return (bv ? b : 0) + (iv ? x * (32'd1 << s) : 0) + de;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic bv, logic [2:0] bs, logic [31:0] b, logic iv, logic [2:0] is,
                       logic [31:0] x, logic [1:0] s, logic [1:0] dz, logic [31:0] d);
    base_vld_i = bv; base_sel_i = bs; base_val_i = b; idx_vld_i = iv; idx_sel_i = is;
    idx_val_i = x; scale_i = s; disp_sz_i = dz; disp_i = d; in_vld_i = 1;
    e_off = f_off(bv, b, iv, x, s, dz, d);
    e_seg = bv && (bs == 3'd4 || bs == 3'd5);
    e_ill = (iv && is == 3'd4) || (!iv && s != 0);
    @(negedge clk_i);
    in_vld_i = 0;
    chk("R7 vld", {31'b0, out_vld_o}, 1);
    chk("R1 offset", offset_o, e_off);
    chk("R6 seg", {31'b0, stack_seg_o}, {31'b0, e_seg});
    chk("R4/R5 illegal", {31'b0, illegal_o}, {31'b0, e_ill});
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    @(negedge clk_i); @(negedge clk_i);
    chk("R8 vld", {31'b0, out_vld_o}, 0);
    chk("R8 offset", offset_o, 0);
    chk("R8 flags", {30'b0, stack_seg_o, illegal_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 all parts with wrap
    apply(1, 3, 32'hFFFF_FFF0, 1, 1, 32'h10, 0, 3, 32'h5);
    // R2 each scale
    for (int s = 0; s < 4; s++) apply(1, 0, 32'h100, 1, 2, 32'h3, 2'(s), 0, 0);
    // R3 sign extension, upper bits ignored
    apply(0, 0, 0, 0, 0, 0, 0, 1, 32'hABCD_12F0);
    chk("R3 8-bit", offset_o, 32'hFFFF_FFF0);
    apply(0, 0, 0, 0, 0, 0, 0, 2, 32'h1234_8001);
    chk("R3 16-bit", offset_o, 32'hFFFF_8001);
    apply(1, 1, 32'h50, 0, 0, 0, 0, 0, 32'hDEAD_BEEF);
    chk("R3 none", offset_o, 32'h50);
    // R4 stack pointer as index
    apply(1, 0, 0, 1, 4, 32'h8, 0, 0, 0);
    chk("R4 sp index", {31'b0, illegal_o}, 1);
    // R5 scale without index, scale ignored
    apply(1, 0, 32'h20, 0, 0, 32'h99, 3, 0, 0);
    chk("R5 scale no idx", {31'b0, illegal_o}, 1);
    chk("R5 offset", offset_o, 32'h20);
    // R6 segments
    apply(1, 4, 32'h1000, 0, 0, 0, 0, 1, 32'h4);
    chk("R6 sp base", {31'b0, stack_seg_o}, 1);
    apply(1, 5, 32'h1000, 1, 0, 1, 1, 0, 0);
    chk("R6 bp base", {31'b0, stack_seg_o}, 1);
    apply(0, 5, 0, 1, 5, 32'h7, 3, 3, 32'h1);
    chk("R6 no base", {31'b0, stack_seg_o}, 0);
    // R7 hold when idle
    base_val_i = 32'h1234; disp_sz_i = 3; disp_i = 32'h55; base_vld_i = 1; base_sel_i = 4;
    @(negedge clk_i);
    chk("R7 idle vld", {31'b0, out_vld_o}, 0);
    chk("R7 hold offset", offset_o, e_off);
    chk("R7 hold seg", {31'b0, stack_seg_o}, {31'b0, e_seg});
    // random
    for (int i = 0; i < 300; i++)
      apply(1'($urandom), 3'($urandom), $urandom, 1'($urandom), 3'($urandom),
            $urandom, 2'($urandom), 2'($urandom), $urandom);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule